// File: doc/BRIEF.md
# UART interrupt identification logic

This block turns the interrupt sources of a 16550-style serial controller into one identification byte and one interrupt line. The enable register lives here, along with three pieces of sticky state: the transmit-holding-empty pending flag, the overrun flag and the break flag. It takes as plain inputs the receive FIFO count and trigger level, the data-ready and FIFO-enable flags, the character-timeout flag, the parity and framing error levels and the four modem-status delta bits. The host register decoder passes single-cycle strobes for the relevant accesses: enable-register write, identification read, line-status read and holding-register write. The transmitter pulses an "emptied" event.

Each cycle the block picks the enabled source with the highest priority and registers its code into the identification byte. It raises the interrupt line whenever that code is not "none". Both outputs reflect the inputs and access strobes sampled at the previous rising clock edge, so the latency is exactly one cycle.

Top module: `uart_iid`

## Requirements
- R1: After reset, `ier_o` is 0, `line_err_o` is 0, `iir_o` is 0x01, `irq_o` is 0, and the holding-empty pending flag is clear.
- R2: When several enabled sources are active, the reported one follows this priority, highest first:
  - line status (enable bit 2, any bit of `line_err_o`);
  - character timeout (enable bit 0);
  - received data (enable bit 0);
  - holding-empty pending (enable bit 1);
  - modem delta (enable bit 3, any bit of `modem_delta_i`).
- R3: `iir_o[3:0]` carries the code of the reported source: 0x6 line status, 0xC timeout, 0x4 received data, 0x2 holding empty, 0x0 modem, 0x1 none. `iir_o[5:4]` is 0.
- R4: `iir_o[7:6]` is 2'b11 when `fifo_en_i` is 1 and 2'b00 otherwise.
- R5: Received data is active only with `rx_ready_i`=1. It also needs either `fifo_en_i`=0 or `rx_count_i >= rx_trig_i`.
- R6: The character-timeout source is masked whenever enable bit 0 is 0.
- R7: An identification read while `iir_o[3:0]` is 0x2 clears the holding-empty pending flag. A read while another code is shown leaves the flag unchanged.
- R8: An enable write that sets bit 1 (previously 0) while `thre_i` is 1 sets the pending flag. A write with bit 1 at 0 clears it. A write keeping bit 1 at 1 leaves it unchanged.
- R9: `tx_empty_i` sets the pending flag. `thr_wr_i` clears it, and wins when both arrive in the same cycle.
- R10: A line-status read clears the overrun bit (`line_err_o[0]`) and the break bit (`line_err_o[3]`). It does not affect the parity (bit 1) or framing (bit 2) levels. A set pulse arriving in the same cycle wins over the clear.
- R11: `irq_o` is 1 exactly when `iir_o[3:0]` is not 0x1.
- R12: `iir_o` and `irq_o` change one clock edge after the input that causes the change, and never before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_data_i | input | 4 | Enable register write data |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| tx_empty_i | input | 1 | Pulse: holding register or transmit FIFO emptied |
| thre_i | input | 1 | Current holding-empty status level |
| ovr_set_i | input | 1 | Pulse: receive overrun occurred |
| brk_set_i | input | 1 | Pulse: break received |
| parity_err_i | input | 1 | Parity error level |
| frame_err_i | input | 1 | Framing error level |
| rx_ready_i | input | 1 | Receive data ready |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| char_tmo_i | input | 1 | Character timeout pending |
| modem_delta_i | input | 4 | Modem status delta bits |
| ier_o | output | 4 | Current enable register |
| line_err_o | output | 4 | Line errors {break, framing, parity, overrun} |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A wrong pending or sticky error flag shows up one cycle after the access that should have changed it. It appears as a wrong code in `iir_o` when the source is enabled and no higher source is active, and the overrun and break flags also appear directly on `line_err_o`. A priority or gating fault appears only under a specific combination of enables and requests. For that reason the combinational path is swept over every enable value against every request pattern and several count/trigger pairs. The stateful flag is then walked through each access sequence, reading `iir_o` after every step.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THRE    = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_code_e;

    // Source slots, lowest index has highest priority
    localparam int NUM_SRC  = 5;
    localparam int SRC_LINE = 0;
    localparam int SRC_TMO  = 1;
    localparam int SRC_RXD  = 2;
    localparam int SRC_THR  = 3;
    localparam int SRC_MDM  = 4;

    function automatic iid_code_e src_code(input int idx);
        case (idx)
            SRC_LINE: return IID_LINE;
            SRC_TMO:  return IID_TIMEOUT;
            SRC_RXD:  return IID_RXDATA;
            SRC_THR:  return IID_THRE;
            SRC_MDM:  return IID_MODEM;
            default:  return IID_NONE;
        endcase
    endfunction

    typedef struct packed {
        logic [3:0] ier;
        logic       thr_pend;
        logic       ovr;
        logic       brk;
    } iid_state_t;

    typedef struct packed {
        logic [7:0] iir;
        logic       irq;
    } iid_out_t;

endpackage

// File: rtl/uart_iid_state.sv
module uart_iid_state
    import uart_iid_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ier_wr_i,
    input  logic [3:0] ier_data_i,
    input  logic       iir_rd_i,
    input  logic       iir_is_thre_i,
    input  logic       thr_wr_i,
    input  logic       tx_empty_i,
    input  logic       thre_i,
    input  logic       lsr_rd_i,
    input  logic       ovr_set_i,
    input  logic       brk_set_i,
    output iid_state_t state_d_o,
    output iid_state_t state_q_o
);

    iid_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // identification read acknowledges the holding-empty source
        if (iir_rd_i && iir_is_thre_i) begin
            st_d.thr_pend = 1'b0;
        end
        if (ier_wr_i) begin
            if (ier_data_i[1] && !st_q.ier[1] && thre_i) begin
                st_d.thr_pend = 1'b1;
            end else if (!ier_data_i[1]) begin
                st_d.thr_pend = 1'b0;
            end
            st_d.ier = ier_data_i;
        end
        if (tx_empty_i) begin
            st_d.thr_pend = 1'b1;
        end
        if (thr_wr_i) begin
            st_d.thr_pend = 1'b0;
        end
        if (lsr_rd_i) begin
            st_d.ovr = 1'b0;
            st_d.brk = 1'b0;
        end
        if (ovr_set_i) begin
            st_d.ovr = 1'b1;
        end
        if (brk_set_i) begin
            st_d.brk = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_d_o = st_d;
    assign state_q_o = st_q;

    assert_thr_wr_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_wr_i |=> !st_q.thr_pend);

    assert_ier_off_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ier_wr_i && !ier_data_i[1] && !tx_empty_i) |=> !st_q.thr_pend);

    assert_lsr_rd_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lsr_rd_i && !ovr_set_i && !brk_set_i) |=> (!st_q.ovr && !st_q.brk));

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier_i,
    input  logic             thr_pend_i,
    input  logic             line_any_i,
    input  logic             timeout_i,
    input  logic             rx_ready_i,
    input  logic             fifo_en_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic             modem_any_i,
    output iid_code_e        code_o
);

    logic [NUM_SRC-1:0] req;
    logic               rx_level_ok;

    assign rx_level_ok = !fifo_en_i || (rx_count_i >= rx_trig_i);

    always_comb begin
        req           = '0;
        req[SRC_LINE] = ier_i[2] && line_any_i;
        req[SRC_TMO]  = ier_i[0] && timeout_i;
        req[SRC_RXD]  = ier_i[0] && rx_ready_i && rx_level_ok;
        req[SRC_THR]  = ier_i[1] && thr_pend_i;
        req[SRC_MDM]  = ier_i[3] && modem_any_i;
    end

    // walk from lowest priority upward so the highest active slot wins
    always_comb begin
        code_o = IID_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                code_o = src_code(i);
            end
        end
    end

endmodule

// File: rtl/uart_iid.sv
module uart_iid
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ier_wr_i,
    input  logic [3:0]       ier_data_i,
    input  logic             iir_rd_i,
    input  logic             thr_wr_i,
    input  logic             lsr_rd_i,
    input  logic             tx_empty_i,
    input  logic             thre_i,
    input  logic             ovr_set_i,
    input  logic             brk_set_i,
    input  logic             parity_err_i,
    input  logic             frame_err_i,
    input  logic             rx_ready_i,
    input  logic             fifo_en_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic             char_tmo_i,
    input  logic [3:0]       modem_delta_i,
    output logic [3:0]       ier_o,
    output logic [3:0]       line_err_o,
    output logic [7:0]       iir_o,
    output logic             irq_o
);

    localparam logic [3:0] RSVD_BITS = 4'b0000;

    iid_state_t st_d, st_q;
    iid_out_t   out_d, out_q;
    iid_code_e  code;
    logic [3:0] err_d;

    uart_iid_state u_state (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .ier_wr_i      (ier_wr_i),
        .ier_data_i    (ier_data_i),
        .iir_rd_i      (iir_rd_i),
        .iir_is_thre_i (out_q.iir[3:0] == IID_THRE),
        .thr_wr_i      (thr_wr_i),
        .tx_empty_i    (tx_empty_i),
        .thre_i        (thre_i),
        .lsr_rd_i      (lsr_rd_i),
        .ovr_set_i     (ovr_set_i),
        .brk_set_i     (brk_set_i),
        .state_d_o     (st_d),
        .state_q_o     (st_q)
    );

    assign err_d = {st_d.brk, frame_err_i, parity_err_i, st_d.ovr};

    uart_iid_prio #(.CNT_W(CNT_W)) u_prio (
        .ier_i       (st_d.ier),
        .thr_pend_i  (st_d.thr_pend),
        .line_any_i  (|err_d),
        .timeout_i   (char_tmo_i),
        .rx_ready_i  (rx_ready_i),
        .fifo_en_i   (fifo_en_i),
        .rx_count_i  (rx_count_i),
        .rx_trig_i   (rx_trig_i),
        .modem_any_i (|modem_delta_i),
        .code_o      (code)
    );

    always_comb begin
        out_d.iir = {{2{fifo_en_i}}, RSVD_BITS[1:0], code};
        out_d.irq = (code != IID_NONE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '{iir: {4'h0, IID_NONE}, irq: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign ier_o      = st_q.ier;
    assign line_err_o = {st_q.brk, frame_err_i, parity_err_i, st_q.ovr};
    assign iir_o      = out_q.iir;
    assign irq_o      = out_q.irq;

    assert_fifo_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_en_i |=> (iir_o[7:6] == 2'b11));

    assert_tmo_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iir_o[3:0] == 4'hC) |-> ier_o[0]);

    assert_modem_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iir_o[3:0] == 4'h0) |-> ier_o[3]);

    assert_irq_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (iir_o[3:0] != 4'h1));

endmodule

// File: tb/uart_iid_tb_top.sv
module uart_iid_tb_top;

    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ier_wr = 0, iir_rd = 0, thr_wr = 0, lsr_rd = 0, tx_empty = 0, thre = 0;
    logic [3:0] ier_data = 0;
    logic ovr_set = 0, brk_set = 0, par_err = 0, frm_err = 0, rx_rdy = 0, fifo_en = 0;
    logic [CNT_W-1:0] rx_cnt = 0, rx_trig = 0;
    logic tmo = 0;
    logic [3:0] mdelta = 0;
    logic [3:0] ier_o, lerr_o;
    logic [7:0] iir_o;
    logic irq_o;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    uart_iid #(.CNT_W(CNT_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ier_wr_i(ier_wr), .ier_data_i(ier_data),
        .iir_rd_i(iir_rd), .thr_wr_i(thr_wr), .lsr_rd_i(lsr_rd), .tx_empty_i(tx_empty),
        .thre_i(thre), .ovr_set_i(ovr_set), .brk_set_i(brk_set), .parity_err_i(par_err),
        .frame_err_i(frm_err), .rx_ready_i(rx_rdy), .fifo_en_i(fifo_en), .rx_count_i(rx_cnt),
        .rx_trig_i(rx_trig), .char_tmo_i(tmo), .modem_delta_i(mdelta),
        .ier_o(ier_o), .line_err_o(lerr_o), .iir_o(iir_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_iir(input logic [3:0] ier, input logic le, input logic to,
                                           input logic dr, input logic fe, input int cnt,
                                           input int trig, input logic thrp, input logic md);
        logic [3:0] c;
        if (ier[2] && le)                             c = 4'h6;
        else if (ier[0] && to)                        c = 4'hC;
        else if (ier[0] && dr && (!fe || cnt >= trig)) c = 4'h4;
        else if (ier[1] && thrp)                      c = 4'h2;
        else if (ier[3] && md)                        c = 4'h0;
        else                                          c = 4'h1;
        return {fe ? 2'b11 : 2'b00, 2'b00, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_iir(input string req, input logic [7:0] exp);
        chk(req, {23'd0, irq_o, iir_o}, {23'd0, exp[3:0] != 4'h1, exp});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one strobed cycle; strobes dropped at the next falling edge
    task automatic strobe_done();
        tick();
        ier_wr = 0; iir_rd = 0; thr_wr = 0; lsr_rd = 0; tx_empty = 0; ovr_set = 0; brk_set = 0;
    endtask

    task automatic wr_ier(input logic [3:0] v);
        ier_wr = 1; ier_data = v;
        strobe_done();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 iir", {24'd0, iir_o}, 32'h01);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 ier", {28'd0, ier_o}, 0);
        chk("R1 line_err", {28'd0, lerr_o}, 0);
        rst_n = 1;
        tick();
        chk("R1 iir after release", {24'd0, iir_o}, 32'h01);

        // R2 R3 R4 R5 R6 R11 sweep, holding-empty flag kept clear (thre=0)
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 64; p++) begin
                int trig, cnt;
                trig = (e % 4 == 0) ? 1 : (e % 4 == 1) ? 4 : (e % 4 == 2) ? 8 : 14;
                cnt  = p[4] ? trig + (e / 4) : trig - 1;
                par_err = p[0]; tmo = p[1]; rx_rdy = p[2]; fifo_en = p[3]; mdelta = p[5] ? 4'b0100 : 4'b0000;
                rx_trig = trig[CNT_W-1:0]; rx_cnt = cnt[CNT_W-1:0];
                ier_wr = 1; ier_data = e[3:0];
                strobe_done();
                chk_iir("R2 R3 R4 R5 R6 R11 sweep",
                        exp_iir(e[3:0], p[0], p[1], p[2], p[3], cnt, trig, 1'b0, p[5]));
            end
        end
        par_err = 0; tmo = 0; rx_rdy = 0; fifo_en = 0; mdelta = 0; rx_cnt = 0; rx_trig = 1;

        // R8 re-arm on enabling bit 1 with thre high
        wr_ier(4'h0);
        thre = 1;
        wr_ier(4'h2);
        chk_iir("R8 enable sets pending", 8'h02);
        // R7 read while showing holding empty clears it
        iir_rd = 1; strobe_done();
        chk_iir("R7 read acknowledges", 8'h01);
        // R8 bit 1 kept at 1 does not re-arm
        wr_ier(4'h3);
        chk_iir("R8 no re-arm when bit kept", 8'h01);
        wr_ier(4'h0);
        wr_ier(4'h2);
        chk_iir("R8 toggle re-arms", 8'h02);
        // R8 clear by turning bit off, observed by re-enabling with thre low
        wr_ier(4'h0);
        thre = 0;
        wr_ier(4'h2);
        chk_iir("R8 disable cleared pending", 8'h01);
        // R9 transmitter emptied sets, holding write clears
        tx_empty = 1; strobe_done();
        chk_iir("R9 tx_empty sets", 8'h02);
        thr_wr = 1; strobe_done();
        chk_iir("R9 thr write clears", 8'h01);
        tx_empty = 1; thr_wr = 1; strobe_done();
        chk_iir("R9 write wins over empty", 8'h01);
        // R7 read while another code shown leaves pending
        tx_empty = 1; strobe_done();
        wr_ier(4'h3);
        rx_rdy = 1; tick();
        chk_iir("R2 rx data over holding empty", 8'h04);
        iir_rd = 1; strobe_done();
        rx_rdy = 0; tick();
        chk_iir("R7 other-code read keeps pending", 8'h02);
        thr_wr = 1; strobe_done();

        // R10 overrun and break sticky, cleared by line status read
        wr_ier(4'h4);
        ovr_set = 1; strobe_done();
        chk_iir("R10 overrun raises line", 8'h06);
        chk("R10 overrun bit", {28'd0, lerr_o}, 32'h1);
        lsr_rd = 1; strobe_done();
        chk_iir("R10 read clears overrun", 8'h01);
        chk("R10 overrun cleared", {28'd0, lerr_o}, 0);
        brk_set = 1; strobe_done();
        chk("R10 break bit", {28'd0, lerr_o}, 32'h8);
        lsr_rd = 1; brk_set = 1; strobe_done();
        chk("R10 set wins over clear", {28'd0, lerr_o}, 32'h8);
        lsr_rd = 1; strobe_done();
        chk("R10 break cleared", {28'd0, lerr_o}, 0);
        frm_err = 1; tick();
        lsr_rd = 1; strobe_done();
        chk_iir("R10 framing level stays", 8'h06);
        chk("R10 framing bit kept", {28'd0, lerr_o}, 32'h4);
        frm_err = 0;

        // R12 latency: no change before the edge, change after it
        wr_ier(4'h1);
        tmo = 1;
        #1;
        chk_iir("R12 not before edge", 8'h01);
        tick();
        chk_iir("R12 after one edge", 8'h0C);
        tmo = 0;
        tick();
        chk_iir("R6 timeout released", 8'h01);

        finish_run();
    end

endmodule